// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte-Lane Unit

This block connects a 32-bit load/store pipeline stage to a word-wide data memory port. On the store side it takes the low two bits of a byte address, a size code, right-justified store data, the processor privilege mode and the configured byte order. From these it produces one write enable per byte lane and the store data moved into the right lanes. On the load side it takes the word returned by memory, pulls out the addressed bytes, right-justifies them and widens them to 32 bits with sign or zero extension.

Whatever the byte order, an object's address is its lowest byte address. Under little-endian order that byte is the least significant byte of the object; under big-endian order it is the most significant. The order actually used is the configured order, flipped by a reverse-order control bit. That bit only counts while the processor runs in user mode. The store and load paths share the address, size and order inputs, so one request drives both paths. A parameter places a register stage on every output.

Top module: `lsu_lane_unit`

## Requirements
- R1: The order in use is big-endian exactly when `cfg_big_endian` XOR (`rev_order` AND `user_mode`) is 1.
- R2: When `user_mode` is 0, `rev_order` has no effect on enables, write data or load data.
- R3: Size code 2'b00 is one byte, 2'b01 is a halfword and 2'b11 is a word. Code 2'b10 sets `len_err`, clears all of `wr_be`, and returns zero on `ld_data` and `wr_data`.
- R4: A halfword at an odd offset, or a word at a nonzero offset, sets `misalign_err`, clears all of `wr_be`, and returns zero on `ld_data` and `wr_data`.
- R5: Under little-endian order, the byte at offset k sits on lane k, which is bits [8k+7:8k]. Bit k of `wr_be` enables that lane. The least significant byte of the item goes to the item's address.
- R6: Under big-endian order, the byte at offset k sits on bits [31-8k:24-8k], which is lane 3-k. The most significant byte of the item goes to the item's address.
- R7: For a valid, aligned access, the number of set bits in `wr_be` equals the item size in bytes (1, 2 or 4).
- R8: Every `wr_data` lane whose enable is clear reads zero.
- R9: When `ld_signed` is 0, the load result is the item right-justified, with the upper bits zero.
- R10: When `ld_signed` is 1, the bits above the item copy the item's top bit.
- R11: With `OUT_REG`=1, every output shows the result of the inputs from the previous clock edge, and synchronous reset clears every output to zero. With `OUT_REG`=0, the outputs follow the inputs with no clock.

Bit 0 of `wr_be` and of each lane index is the byte on bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| byte_off | input | 2 | Low two bits of the byte address |
| acc_len | input | 2 | Size code: 00 byte, 01 half, 11 word, 10 reserved |
| cfg_big_endian | input | 1 | Configured byte order, 1 = big-endian |
| rev_order | input | 1 | Reverse-order control bit from the status register |
| user_mode | input | 1 | 1 while the processor runs in user mode |
| st_data | input | 32 | Right-justified store data |
| ld_word | input | 32 | Word returned by memory |
| ld_signed | input | 1 | 1 = sign-extend the load, 0 = zero-extend |
| wr_be | output | 4 | Per-lane write enables |
| wr_data | output | 32 | Store data placed in its lanes |
| ld_data | output | 32 | Right-justified, extended load result |
| misalign_err | output | 1 | Access is not aligned to its size |
| len_err | output | 1 | Reserved size code used |

## Verification
The bench builds two copies of the block side by side. One copy has `OUT_REG`=0, so every offset, size, order and mode combination can be checked in the same cycle it is applied. The other copy has `OUT_REG`=1, so the one-cycle delay and the reset-cleared outputs can be seen against the same expected values. Running both copies on one stimulus stream shows that the register stage changes only the timing and never the lane mapping.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int OFF_W   = $clog2(LANES);
    localparam int CNT_W   = OFF_W + 1;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'b00,
        LEN_HALF = 2'b01,
        LEN_RSVD = 2'b10,
        LEN_WORD = 2'b11
    } acc_len_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
        logic              misalign;
        logic              bad_len;
    } st_res_t;

    typedef struct packed {
        st_res_t           st;
        logic [WORD_W-1:0] ld;
    } lane_out_t;

    // item size in bytes, zero for the reserved code
    function automatic logic [CNT_W-1:0] item_bytes(acc_len_e l);
        case (l)
            LEN_BYTE: item_bytes = CNT_W'(1);
            LEN_HALF: item_bytes = CNT_W'(2);
            LEN_WORD: item_bytes = CNT_W'(4);
            default:  item_bytes = '0;
        endcase
    endfunction

    function automatic logic off_misaligned(acc_len_e l, logic [OFF_W-1:0] off);
        case (l)
            LEN_HALF: off_misaligned = off[0];
            LEN_WORD: off_misaligned = (off != '0);
            default:  off_misaligned = 1'b0;
        endcase
    endfunction

    // lane holding the least significant item byte
    function automatic logic [OFF_W-1:0] lane_shift(acc_len_e l, logic [OFF_W-1:0] off,
                                                    logic big);
        logic [CNT_W-1:0] tmp;
        tmp = CNT_W'(LANES) - item_bytes(l) - {1'b0, off};
        lane_shift = big ? tmp[OFF_W-1:0] : off;
    endfunction

    function automatic logic [LANES-1:0] size_mask(acc_len_e l);
        case (l)
            LEN_BYTE: size_mask = LANES'(4'b0001);
            LEN_HALF: size_mask = LANES'(4'b0011);
            LEN_WORD: size_mask = LANES'(4'b1111);
            default:  size_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/lane_order_ctrl.sv
module lane_order_ctrl (
    input  logic cfg_big,
    input  logic rev_bit,
    input  logic user_mode,
    output logic eff_big
);
    logic rev_live;

    assign rev_live = rev_bit & user_mode;
    assign eff_big  = cfg_big ^ rev_live;

    always_comb begin
        // R2
        kernel_rev_ignored_chk: assert (user_mode || (eff_big == cfg_big));
    end

endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
    import lsu_lane_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [OFF_W-1:0]         off,
    input  acc_len_e                 len,
    input  logic                     eff_big,
    input  logic [NLANES*BYTE_W-1:0] data_in,
    output st_res_t                  res
);
    localparam int DW = NLANES * BYTE_W;

    logic [OFF_W-1:0]  sh;
    logic              bad, mis, err;
    logic [NLANES-1:0] be;
    logic [DW-1:0]     moved;
    logic [DW-1:0]     lane_data;

    assign sh    = lane_shift(len, off, eff_big);
    assign bad   = (len == LEN_RSVD);
    assign mis   = off_misaligned(len, off);
    assign err   = bad | mis;
    assign be    = err ? '0 : (size_mask(len) << sh);
    assign moved = data_in << {sh, 3'b000};

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign lane_data[g*BYTE_W +: BYTE_W] = be[g] ? moved[g*BYTE_W +: BYTE_W] : '0;
    end

    assign res.be       = be;
    assign res.data     = lane_data;
    assign res.misalign = mis;
    assign res.bad_len  = bad;

    always_comb begin
        // R3
        rsvd_len_no_be_chk: assert (len != LEN_RSVD || (res.bad_len && res.be == '0));
        // R4
        misalign_no_be_chk: assert (!res.misalign || res.be == '0);
        // R7
        be_count_chk: assert (res.misalign || res.bad_len
                              || $countones(res.be) == int'(item_bytes(len)));
        // R8
        for (int i = 0; i < NLANES; i++) begin
            idle_lane_zero_chk: assert (res.be[i] || res.data[i*BYTE_W +: BYTE_W] == '0);
        end
    end

endmodule

// File: rtl/load_lane_ext.sv
module load_lane_ext
    import lsu_lane_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [OFF_W-1:0]         off,
    input  acc_len_e                 len,
    input  logic                     eff_big,
    input  logic                     sgn,
    input  logic [NLANES*BYTE_W-1:0] word_in,
    output logic [NLANES*BYTE_W-1:0] data_out
);
    localparam int DW = NLANES * BYTE_W;
    localparam int HW = 2 * BYTE_W;

    logic [OFF_W-1:0] sh;
    logic             err;
    logic [DW-1:0]    rj;

    assign sh  = lane_shift(len, off, eff_big);
    assign err = (len == LEN_RSVD) | off_misaligned(len, off);
    assign rj  = word_in >> {sh, 3'b000};

    always_comb begin
        data_out = '0;
        if (!err) begin
            case (len)
                LEN_BYTE: data_out = {{(DW-BYTE_W){sgn & rj[BYTE_W-1]}}, rj[BYTE_W-1:0]};
                LEN_HALF: data_out = {{(DW-HW){sgn & rj[HW-1]}}, rj[HW-1:0]};
                default:  data_out = rj;
            endcase
        end
    end

    always_comb begin
        // R9
        zero_ext_chk: assert (sgn || len != LEN_BYTE || data_out[DW-1:BYTE_W] == '0);
        // R10
        sign_ext_chk: assert (!sgn || len != LEN_HALF || err
                              || data_out[DW-1:HW] == {(DW-HW){data_out[HW-1]}});
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [1:0]        acc_len,
    input  logic              cfg_big_endian,
    input  logic              rev_order,
    input  logic              user_mode,
    input  logic [WORD_W-1:0] st_data,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              ld_signed,
    output logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ld_data,
    output logic              misalign_err,
    output logic              len_err
);
    acc_len_e   len;
    logic       eff_big;
    st_res_t    st_res;
    logic [WORD_W-1:0] ld_res;
    lane_out_t  nxt, cur;

    assign len = acc_len_e'(acc_len);

    lane_order_ctrl u_order (
        .cfg_big   (cfg_big_endian),
        .rev_bit   (rev_order),
        .user_mode (user_mode),
        .eff_big   (eff_big)
    );

    store_lane_gen #(.NLANES(LANES)) u_store (
        .off     (byte_off),
        .len     (len),
        .eff_big (eff_big),
        .data_in (st_data),
        .res     (st_res)
    );

    load_lane_ext #(.NLANES(LANES)) u_load (
        .off      (byte_off),
        .len      (len),
        .eff_big  (eff_big),
        .sgn      (ld_signed),
        .word_in  (ld_word),
        .data_out (ld_res)
    );

    assign nxt.st = st_res;
    assign nxt.ld = ld_res;

    if (OUT_REG) begin : g_reg
        logic past_ok;
        always_ff @(posedge clk) begin
            if (rst) begin
                cur     <= '0;
                past_ok <= 1'b0;
            end else begin
                cur     <= nxt;
                past_ok <= 1'b1;
            end
        end

        // R11
        reg_stage_chk: assert property (@(posedge clk) disable iff (rst)
            past_ok |-> (wr_be == $past(st_res.be) && ld_data == $past(ld_res)));
    end else begin : g_comb
        assign cur = nxt;
    end

    assign wr_be        = cur.st.be;
    assign wr_data      = cur.st.data;
    assign misalign_err = cur.st.misalign;
    assign len_err      = cur.st.bad_len;
    assign ld_data      = cur.ld;

endmodule

// File: tb/lsu_lane_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  byte_off;
    logic [1:0]  acc_len;
    logic        cfg_big_endian, rev_order, user_mode, ld_signed;
    logic [31:0] st_data, ld_word;

    logic [3:0]  wr_be,   wr_be_c;
    logic [31:0] wr_data, wr_data_c, ld_data, ld_data_c;
    logic        misalign_err, misalign_err_c, len_err, len_err_c;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsu_lane_unit #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .byte_off(byte_off), .acc_len(acc_len),
        .cfg_big_endian(cfg_big_endian), .rev_order(rev_order), .user_mode(user_mode),
        .st_data(st_data), .ld_word(ld_word), .ld_signed(ld_signed),
        .wr_be(wr_be), .wr_data(wr_data), .ld_data(ld_data),
        .misalign_err(misalign_err), .len_err(len_err)
    );

    lsu_lane_unit #(.OUT_REG(1'b0)) dut_c_i (
        .clk(clk), .rst(rst), .byte_off(byte_off), .acc_len(acc_len),
        .cfg_big_endian(cfg_big_endian), .rev_order(rev_order), .user_mode(user_mode),
        .st_data(st_data), .ld_word(ld_word), .ld_signed(ld_signed),
        .wr_be(wr_be_c), .wr_data(wr_data_c), .ld_data(ld_data_c),
        .misalign_err(misalign_err_c), .len_err(len_err_c)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model: walk the item byte by byte through memory addresses
    logic [3:0]  e_be;
    logic [31:0] e_wd, e_ld;
    logic        e_mis, e_bad;
    string       e_tag, e_ldtag;

    task automatic model();
        int n, addr, ib, lane;
        bit eff;
        eff   = cfg_big_endian ^ (rev_order & user_mode);
        n     = (acc_len == 2'b00) ? 1 : (acc_len == 2'b01) ? 2 : (acc_len == 2'b11) ? 4 : 0;
        e_bad = (acc_len == 2'b10);
        e_mis = (n == 2 && byte_off[0]) || (n == 4 && byte_off != 2'b00);
        e_be = '0; e_wd = '0; e_ld = '0;
        if (!e_bad && !e_mis) begin
            for (int i = 0; i < n; i++) begin
                addr = int'(byte_off) + i;
                ib   = eff ? (n - 1 - i) : i;
                lane = eff ? (3 - addr) : addr;
                e_be[lane] = 1'b1;
                e_wd[lane*8 +: 8] = st_data[ib*8 +: 8];
                e_ld[ib*8 +: 8]   = ld_word[lane*8 +: 8];
            end
            if (ld_signed && e_ld[8*n-1])
                for (int b = 8*n; b < 32; b++) e_ld[b] = 1'b1;
        end
        if (e_bad)                     e_tag = "R3";
        else if (e_mis)                e_tag = "R4";
        else if (rev_order && user_mode)  e_tag = "R1";
        else if (rev_order)            e_tag = "R2";
        else if (eff)                  e_tag = "R6";
        else                           e_tag = "R5";
        e_ldtag = ld_signed ? "R10" : "R9";
    endtask

    task automatic compare_c();
        chk(wr_be_c == e_be, e_tag, "comb wr_be", 32'(wr_be_c), 32'(e_be));
        chk($countones(wr_be_c) == $countones(e_be), "R7", "comb enable count",
            32'($countones(wr_be_c)), 32'($countones(e_be)));
        chk(wr_data_c == e_wd, "R8", "comb wr_data", wr_data_c, e_wd);
        chk(ld_data_c == e_ld, e_ldtag, "comb ld_data", ld_data_c, e_ld);
        chk(misalign_err_c == e_mis && len_err_c == e_bad, e_tag, "comb flags",
            {30'd0, misalign_err_c, len_err_c}, {30'd0, e_mis, e_bad});
    endtask

    task automatic compare_r(input logic [3:0] be, input logic [31:0] wd, ld,
                             input logic mis, bad);
        chk(wr_be == be && wr_data == wd, "R11", "reg store", {wr_be, wr_data[27:0]},
            {be, wd[27:0]});
        chk(ld_data == ld && misalign_err == mis && len_err == bad, "R11", "reg load",
            ld_data, ld);
    endtask

    task automatic apply(input logic [1:0] off, len, input bit big, re, usr, sgn,
                         input logic [31:0] sd, lw);
        logic [3:0] hb; logic [31:0] hw, hl; logic hm, hd;
        @(negedge clk);
        byte_off = off; acc_len = len; cfg_big_endian = big; rev_order = re;
        user_mode = usr; ld_signed = sgn; st_data = sd; ld_word = lw;
        #1;
        model();
        compare_c();
        hb = e_be; hw = e_wd; hl = e_ld; hm = e_mis; hd = e_bad;
        @(posedge clk); #1;
        compare_r(hb, hw, hl, hm, hd);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        byte_off = 2'b01; acc_len = 2'b00; cfg_big_endian = 1'b0; rev_order = 1'b0;
        user_mode = 1'b0; ld_signed = 1'b1; st_data = 32'hA5A5_A5A5; ld_word = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset clears registered outputs
        chk(wr_be == 4'h0 && wr_data == 32'h0, "R11", "reset store outputs",
            {wr_be, wr_data[27:0]}, 32'h0);
        chk(ld_data == 32'h0 && !misalign_err && !len_err, "R11", "reset load outputs",
            ld_data, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        apply(2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0081, 32'h4433_2281); // R5 R10
        apply(2'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0081, 32'h8133_2211); // R6 R9
        apply(2'd2, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_BEEF, 32'h1122_8001); // R6 R10
        apply(2'd1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1234, 32'h1111_1111); // R4
        apply(2'd2, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1111_1111); // R4
        apply(2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1111_1111); // R3
        apply(2'd3, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_00C3, 32'h7766_5544); // R1
        apply(2'd3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_00C3, 32'h7766_5544); // R2

        // full sweep of offset, size, order and mode with varied data
        for (int rep = 0; rep < 4; rep++) begin
            for (int k = 0; k < 256; k++) begin
                apply(2'(k), 2'(k >> 2), k[4], k[5], k[6], k[7], $urandom, $urandom);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule